// File: doc/BRIEF.md
# Power-Up and Host-Reset Bring-Up Sequencer

This block orders the bring-up of a network interface after supplies come up and again each time the host bus releases its fundamental reset. It holds the internal reset until supplies are good and the crystal oscillator has settled for a set number of core clock cycles. It then asks an external loader to read configuration from nonvolatile memory, and it keeps the PHY in power-down until that load reports completion. After the first load it copies the loaded wake-enable bit to its output.

Each release of the host reset starts a fresh sequence. The block issues a second load request, forces the PHY into power-down and clears wake-enable. It opens the link-training, configuration-accept and configuration-response windows after three separate delays counted from that release. It also tracks the device power state: reset, powered but uninitialized, and active once software turns on memory access.

The host reset input is asynchronous and passes through a synchronizer. All delays count core clock cycles and are parameters.

Top module: `bringup_seq`

## Requirements
- R1: `int_rst` is 1 whenever `pwr_good` or `osc_stable` is low. It falls at the SETTLE_CYC-th rising clock edge that samples `osc_stable` high while power is good.
- R2: `nvm_load_req` is 1 for exactly one cycle, the first cycle in which `int_rst` is 0.
- R3: An `nvm_done` pulse that ends the power-on load clears `phy_pwr_dn` and loads `wake_en` from `nvm_wake_bit` at that clock edge.
- R4: While `int_rst` is 0, release of `host_rst_n` raises `nvm_load_req` for one cycle, SYNC_STAGES cycles after release. On the next cycle `phy_pwr_dn` is 1, `wake_en` is 0 and `pwr_state` is 2'b01.
- R5: An `nvm_done` pulse that ends a host-reset load clears `phy_pwr_dn` and leaves `wake_en` at 0.
- R6: `train_en` rises exactly TRAIN_DLY cycles after `pwr_state` first shows 2'b01. It stays high while the host reset remains released.
- R7: `cfg_accept` rises CFG_DLY cycles and `cfg_rsp_ok` rises RSP_DLY cycles after `pwr_state` first shows 2'b01. RSP_DLY is at least CFG_DLY.
- R8: `pwr_state` encodes reset as 2'b00, uninitialized as 2'b01 and active as 2'b10. An `mem_en_wr` strobe moves 2'b01 to 2'b10 and has no effect in any other state.
- R9: Driving `host_rst_n` low immediately forces `pwr_state` to 2'b00 and clears `train_en`, `cfg_accept` and `cfg_rsp_ok`. A later release restarts all three delays from zero.
- R10: An `nvm_done` pulse with no load outstanding leaves `phy_pwr_dn` and `wake_en` unchanged.
- R11: Loss of `osc_stable` after start-up asserts `int_rst` at the next edge and returns `phy_pwr_dn` to 1 and `wake_en` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| pwr_good | input | 1 | All supplies good; low acts as asynchronous reset |
| osc_stable | input | 1 | Oscillator reports a stable clock |
| host_rst_n | input | 1 | Active-low fundamental reset from the host, asynchronous |
| nvm_done | input | 1 | One-cycle completion pulse from the memory loader |
| nvm_wake_bit | input | 1 | Wake-enable value read by the loader |
| mem_en_wr | input | 1 | Strobe: software wrote 1 to the memory access enable bit |
| int_rst | output | 1 | Internal reset, active high |
| nvm_load_req | output | 1 | One-cycle request to start a memory load |
| phy_pwr_dn | output | 1 | PHY power-down control |
| wake_en | output | 1 | Wake-up enable |
| train_en | output | 1 | Link training permitted |
| cfg_accept | output | 1 | Configuration requests may be accepted |
| cfg_rsp_ok | output | 1 | Configuration responses may be sent |
| pwr_state | output | 2 | Device power state code |

## Verification
The bench targets the following failure modes.

- A settle counter that is off by one would move the fall of `int_rst` by one edge.
- A missing one-cycle qualifier would repeat the load request on consecutive cycles.
- A sequencer that reuses the power-on path for the host load would let the loaded bit reach `wake_en` after a host reset.
- A stray completion pulse that is not gated by the outstanding flag would clear PHY power-down too early.
- Delay windows that are not cleared on reset re-entry would open early when the host reset is released a second time.
- Logic that honors the memory-enable strobe outside the uninitialized state would jump straight from reset to active.

A long stretch of pseudo-random oscillator drops, host resets and completion pulses is then checked against the reference model on every cycle.

// File: rtl/brs_pkg.sv
package brs_pkg;

   typedef enum logic [1:0] {
      PS_RST    = 2'b00,
      PS_UNINIT = 2'b01,
      PS_ACTIVE = 2'b10
   } pstate_e;

   localparam int unsigned NUM_WIN = 3;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

endpackage

// File: rtl/brs_sync.sv
module brs_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("brs_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) q <= 1'b0;
         else         q <= 1'b1;
      end
   end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) sh <= '0;
         else         sh <= {sh[STAGES-2:0], 1'b1};
      end
      assign q = sh[STAGES-1];
   end
endmodule

// File: rtl/brs_settle.sv
module brs_settle #(
   parameter int unsigned SETTLE_CYC = 16
) (
   input  logic clk,
   input  logic arst_n,
   input  logic osc_ok,
   output logic released
);
   localparam int unsigned CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
   localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("brs_settle: SETTLE_CYC must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt      <= '0;
         released <= 1'b0;
      end else if (!osc_ok) begin
         cnt      <= '0;
         released <= 1'b0;
      end else if (!released) begin
         if (cnt == LAST) released <= 1'b1;
         else             cnt      <= cnt + 1'b1;
      end
   end

   // R1 / R11: an unstable oscillator always pulls the block back into reset
   a_r1_osc_low_holds_rst: assert property (@(posedge clk) disable iff (!arst_n)
      !osc_ok |=> !released);
   a_r1_release_after_osc: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(released) |-> $past(osc_ok));
endmodule

// File: rtl/brs_window.sv
module brs_window #(
   parameter int unsigned NUM = 3,
   parameter int unsigned LIMITS [NUM] = '{1, 2, 3},
   parameter int unsigned MAX_V = 3
) (
   input  logic           clk,
   input  logic           arst_n,
   input  logic           clr,
   input  logic           run,
   output logic [NUM-1:0] hit
);
   localparam int unsigned CW = $clog2(MAX_V + 1);
   localparam logic [CW-1:0] TOP = CW'(MAX_V);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                  cnt <= '0;
      else if (clr)                 cnt <= '0;
      else if (run && cnt != TOP)   cnt <= cnt + 1'b1;
   end

   for (genvar i = 0; i < NUM; i++) begin : g_hit
      if (LIMITS[i] > MAX_V || LIMITS[i] < 1) begin : g_bad_limit
         $error("brs_window: each limit must lie in 1..MAX_V");
      end
      assign hit[i] = run && (cnt >= CW'(LIMITS[i]));

      // R6: once a window has opened it stays open while the link stays up
      a_r6_hit_sticky: assert property (@(posedge clk) disable iff (!arst_n)
         (hit[i] && !clr) |=> (hit[i] || !run));
   end
endmodule

// File: rtl/bringup_seq.sv
module bringup_seq
   import brs_pkg::*;
#(
   parameter int unsigned SETTLE_CYC  = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TRAIN_DLY   = 20,
   parameter int unsigned CFG_DLY     = 24,
   parameter int unsigned RSP_DLY     = 32
) (
   input  logic       clk,
   input  logic       pwr_good,
   input  logic       osc_stable,
   input  logic       host_rst_n,
   input  logic       nvm_done,
   input  logic       nvm_wake_bit,
   input  logic       mem_en_wr,
   output logic       int_rst,
   output logic       nvm_load_req,
   output logic       phy_pwr_dn,
   output logic       wake_en,
   output logic       train_en,
   output logic       cfg_accept,
   output logic       cfg_rsp_ok,
   output logic [1:0] pwr_state
);
   localparam int unsigned MAX_D = max3(TRAIN_DLY, CFG_DLY, RSP_DLY);

   if (RSP_DLY < CFG_DLY) begin : g_bad_order
      $error("bringup_seq: RSP_DLY must not be below CFG_DLY");
   end

   logic rel, rel_d, hsync, sync_arst_n;
   logic busy, kind_host, phy_dn, wake, host_up;
   logic por_pulse, host_evt, link_up, win_clr;
   logic [NUM_WIN-1:0] win_hit;
   pstate_e st;

   assign sync_arst_n = pwr_good & host_rst_n;

   brs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (sync_arst_n),
      .q      (hsync)
   );

   brs_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
      .clk      (clk),
      .arst_n   (pwr_good),
      .osc_ok   (osc_stable),
      .released (rel)
   );

   assign por_pulse = rel && !rel_d;
   assign host_evt  = rel_d && hsync && !host_up;
   assign link_up   = host_up && hsync;
   assign win_clr   = !rel || host_evt || !hsync;

   brs_window #(
      .NUM    (NUM_WIN),
      .LIMITS ('{TRAIN_DLY, CFG_DLY, RSP_DLY}),
      .MAX_V  (MAX_D)
   ) u_window (
      .clk    (clk),
      .arst_n (pwr_good),
      .clr    (win_clr),
      .run    (link_up),
      .hit    (win_hit)
   );

   always_ff @(posedge clk or negedge pwr_good) begin
      if (!pwr_good) begin
         rel_d     <= 1'b0;
         busy      <= 1'b0;
         kind_host <= 1'b0;
         phy_dn    <= 1'b1;
         wake      <= 1'b0;
         host_up   <= 1'b0;
         st        <= PS_UNINIT;
      end else if (!rel) begin
         rel_d     <= 1'b0;
         busy      <= 1'b0;
         kind_host <= 1'b0;
         phy_dn    <= 1'b1;
         wake      <= 1'b0;
         host_up   <= 1'b0;
         st        <= PS_UNINIT;
      end else begin
         rel_d <= 1'b1;
         if (host_evt) begin
            host_up   <= 1'b1;
            busy      <= 1'b1;
            kind_host <= 1'b1;
            phy_dn    <= 1'b1;
            wake      <= 1'b0;
         end else if (por_pulse) begin
            busy      <= 1'b1;
            kind_host <= 1'b0;
         end else if (busy && nvm_done) begin
            busy   <= 1'b0;
            phy_dn <= 1'b0;
            if (!kind_host) wake <= nvm_wake_bit;
         end
         if (!hsync) host_up <= 1'b0;
         if (host_evt || !hsync)
            st <= PS_UNINIT;
         else if (link_up && mem_en_wr && st == PS_UNINIT)
            st <= PS_ACTIVE;
      end
   end

   assign int_rst      = !rel;
   assign nvm_load_req = por_pulse || host_evt;
   assign phy_pwr_dn   = phy_dn;
   assign wake_en      = wake;
   assign train_en     = win_hit[0];
   assign cfg_accept   = win_hit[1];
   assign cfg_rsp_ok   = win_hit[2];
   assign pwr_state    = link_up ? st : PS_RST;

   // R2: leaving internal reset always requests a load
   a_r2_req_on_release: assert property (@(posedge clk) disable iff (!pwr_good)
      $fell(int_rst) |-> nvm_load_req);
   // R4: a host-reset release parks the PHY and drops wake
   a_r4_host_parks_phy: assert property (@(posedge clk) disable iff (!pwr_good)
      (host_evt && osc_stable) |=> (phy_pwr_dn && !wake_en));
   // R5: a host-reset load never turns wake back on
   a_r5_host_load_no_wake: assert property (@(posedge clk) disable iff (!pwr_good)
      (busy && kind_host && nvm_done && !host_evt) |=> !wake_en);
   // R7: responses never open before acceptance
   a_r7_rsp_implies_cfg: assert property (@(posedge clk) disable iff (!pwr_good)
      cfg_rsp_ok |-> cfg_accept);
   // R8: only the three legal codes, and active only after uninitialized
   a_r8_state_legal: assert property (@(posedge clk) disable iff (!pwr_good)
      pwr_state != 2'b11);
   a_r8_no_skip: assert property (@(posedge clk) disable iff (!pwr_good)
      (pwr_state == 2'b10) |-> ($past(pwr_state) != 2'b00));
   // R9: host reset closes every window at once
   a_r9_host_low_closes: assert property (@(posedge clk) disable iff (!pwr_good)
      !host_rst_n |-> (pwr_state == 2'b00 && !train_en && !cfg_accept && !cfg_rsp_ok));
   // R10: a stray completion pulse leaves PHY and wake alone
   a_r10_stray_done: assert property (@(posedge clk) disable iff (!pwr_good)
      (!busy && nvm_done && !nvm_load_req && !int_rst && osc_stable)
         |=> ($stable(phy_pwr_dn) && $stable(wake_en)));
   // R11: internal reset forces the PHY down and wake off
   a_r11_rst_parks: assert property (@(posedge clk) disable iff (!pwr_good)
      $past(int_rst) |-> (phy_pwr_dn && !wake_en));
endmodule

// File: tb/bringup_seq_bench.sv
module bringup_seq_bench;
   localparam int CLK_P  = 10;
   localparam int SETTLE = 5;
   localparam int SYNC   = 2;
   localparam int TRAIN  = 4;
   localparam int CFG    = 6;
   localparam int RSP    = 9;
   localparam int MAXD   = 9;

   logic clk = 1'b0;
   logic pwr_good = 1'b0, osc_stable = 1'b0, host_rst_n = 1'b0;
   logic nvm_done = 1'b0, nvm_wake_bit = 1'b0, mem_en_wr = 1'b0;
   logic int_rst, nvm_load_req, phy_pwr_dn, wake_en, train_en, cfg_accept, cfg_rsp_ok;
   logic [1:0] pwr_state;

   int tests = 0, fails = 0;
   bit finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   bringup_seq #(
      .SETTLE_CYC(SETTLE), .SYNC_STAGES(SYNC), .TRAIN_DLY(TRAIN),
      .CFG_DLY(CFG), .RSP_DLY(RSP)
   ) u_bringup_seq (
      .clk(clk), .pwr_good(pwr_good), .osc_stable(osc_stable), .host_rst_n(host_rst_n),
      .nvm_done(nvm_done), .nvm_wake_bit(nvm_wake_bit), .mem_en_wr(mem_en_wr),
      .int_rst(int_rst), .nvm_load_req(nvm_load_req), .phy_pwr_dn(phy_pwr_dn),
      .wake_en(wake_en), .train_en(train_en), .cfg_accept(cfg_accept),
      .cfg_rsp_ok(cfg_rsp_ok), .pwr_state(pwr_state)
   );

   // behavioural reference state
   int m_cnt, m_sh, m_el, m_st;
   bit m_rel, m_reld, m_busy, m_kind, m_phy, m_wake, m_up;

   task automatic model_reset();
      m_cnt = 0; m_sh = 0; m_el = 0; m_st = 1;
      m_rel = 0; m_reld = 0; m_busy = 0; m_kind = 0; m_phy = 1; m_wake = 0; m_up = 0;
   endtask

   task automatic check(string req, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
      end
   endtask

   task automatic model_step();
      bit hs, lu, por, hev;
      int n_cnt, n_sh, n_el, n_st;
      bit n_rel, n_reld, n_busy, n_kind, n_phy, n_wake, n_up;
      if (!pwr_good) begin model_reset(); return; end
      if (!host_rst_n) m_sh = 0;
      hs  = (m_sh == SYNC);
      lu  = m_up && hs;
      por = m_rel && !m_reld;
      hev = m_reld && hs && !m_up;
      n_sh = !host_rst_n ? 0 : (m_sh < SYNC ? m_sh + 1 : m_sh);
      n_cnt = m_cnt; n_rel = m_rel;
      if (!osc_stable) begin n_cnt = 0; n_rel = 0; end
      else if (!m_rel) begin
         if (m_cnt == SETTLE - 1) n_rel = 1; else n_cnt = m_cnt + 1;
      end
      n_reld = m_reld; n_busy = m_busy; n_kind = m_kind; n_phy = m_phy;
      n_wake = m_wake; n_up = m_up; n_st = m_st; n_el = m_el;
      if (!m_rel) begin
         n_reld = 0; n_busy = 0; n_kind = 0; n_phy = 1; n_wake = 0; n_up = 0; n_st = 1; n_el = 0;
      end else begin
         n_reld = 1;
         if (hev) begin n_up = 1; n_busy = 1; n_kind = 1; n_phy = 1; n_wake = 0; end
         else if (por) begin n_busy = 1; n_kind = 0; end
         else if (m_busy && nvm_done) begin
            n_busy = 0; n_phy = 0;
            if (!m_kind) n_wake = nvm_wake_bit;
         end
         if (!hs) n_up = 0;
         if (hev || !hs) begin n_st = 1; n_el = 0; end
         else begin
            if (lu && mem_en_wr && m_st == 1) n_st = 2;
            if (lu && m_el < MAXD) n_el = m_el + 1;
         end
      end
      m_cnt = n_cnt; m_rel = n_rel; m_sh = n_sh; m_reld = n_reld; m_busy = n_busy;
      m_kind = n_kind; m_phy = n_phy; m_wake = n_wake; m_up = n_up; m_st = n_st; m_el = n_el;
   endtask

   task automatic compare_all();
      bit hs, lu;
      hs = host_rst_n && (m_sh == SYNC);
      lu = m_up && hs;
      check("R1 int_rst", int_rst, !m_rel);
      check("R2/R4 nvm_load_req", nvm_load_req, (m_rel && !m_reld) || (m_reld && hs && !m_up));
      check("R3 phy_pwr_dn", phy_pwr_dn, m_phy);
      check("R3 wake_en", wake_en, m_wake);
      check("R6 train_en", train_en, lu && m_el >= TRAIN);
      check("R7 cfg_accept", cfg_accept, lu && m_el >= CFG);
      check("R7 cfg_rsp_ok", cfg_rsp_ok, lu && m_el >= RSP);
      check("R8 pwr_state", pwr_state, lu ? m_st : 0);
   endtask

   task automatic tick();
      @(negedge clk);
      model_step();
      compare_all();
   endtask

   function automatic logic [15:0] lfsr(input logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int k, t_tr, t_cf, t_rs;
      logic [15:0] s;
      model_reset();
      repeat (3) tick();
      // reset state
      check("R1 reset int_rst", int_rst, 1);
      check("R8 reset state", pwr_state, 0);
      check("R11 reset phy", phy_pwr_dn, 1);
      pwr_good = 1'b1;
      repeat (2) tick();
      check("R1 osc low keeps reset", int_rst, 1);
      osc_stable = 1'b1;
      k = 0;
      do begin tick(); k++; end while (int_rst && k < 50);
      check("R1 settle cycles", k, SETTLE);
      check("R2 request at release", nvm_load_req, 1);
      tick();
      check("R2 request one cycle", nvm_load_req, 0);
      repeat (2) tick();
      nvm_done = 1'b1; nvm_wake_bit = 1'b1;
      tick();
      nvm_done = 1'b0; nvm_wake_bit = 1'b0;
      check("R3 phy released", phy_pwr_dn, 0);
      check("R3 wake loaded", wake_en, 1);
      tick();
      nvm_done = 1'b1;
      tick();
      nvm_done = 1'b0;
      check("R10 stray done wake", wake_en, 1);
      check("R10 stray done phy", phy_pwr_dn, 0);
      // first host release
      host_rst_n = 1'b1;
      k = 0;
      do begin tick(); k++; end while (!nvm_load_req && k < 50);
      check("R4 host request delay", k, SYNC);
      tick();
      check("R4 phy parked", phy_pwr_dn, 1);
      check("R4 wake cleared", wake_en, 0);
      check("R4 state uninit", pwr_state, 1);
      t_tr = -1; t_cf = -1; t_rs = -1;
      for (int j = 1; j <= 14; j++) begin
         nvm_done = (j == 3); nvm_wake_bit = 1'b1;
         tick();
         if (j == 3) begin
            check("R5 host load phy", phy_pwr_dn, 0);
            check("R5 host load wake", wake_en, 0);
         end
         if (train_en && t_tr < 0) t_tr = j;
         if (cfg_accept && t_cf < 0) t_cf = j;
         if (cfg_rsp_ok && t_rs < 0) t_rs = j;
      end
      nvm_done = 1'b0; nvm_wake_bit = 1'b0;
      check("R6 train delay", t_tr, TRAIN);
      check("R7 accept delay", t_cf, CFG);
      check("R7 response delay", t_rs, RSP);
      mem_en_wr = 1'b1;
      tick();
      mem_en_wr = 1'b0;
      check("R8 active", pwr_state, 2);
      // host reset mid-window, strobe while in reset
      host_rst_n = 1'b0;
      #1;
      check("R9 immediate state", pwr_state, 0);
      check("R9 immediate train", train_en, 0);
      mem_en_wr = 1'b1;
      tick();
      mem_en_wr = 1'b0;
      check("R8 strobe ignored in reset", pwr_state, 0);
      host_rst_n = 1'b1;
      repeat (SYNC + 1) tick();
      check("R9 restart uninit", pwr_state, 1);
      repeat (TRAIN - 1) tick();
      check("R9 window restarted", train_en, 0);
      tick();
      check("R9 window reopens", train_en, 1);
      // oscillator loss
      osc_stable = 1'b0;
      tick();
      osc_stable = 1'b1;
      check("R11 int_rst", int_rst, 1);
      check("R11 phy", phy_pwr_dn, 1);
      check("R11 wake", wake_en, 0);
      // pseudo-random soak against the model
      s = 16'hACE1;
      for (int j = 0; j < 3000; j++) begin
         s = lfsr(s);
         osc_stable   = (s[4:0] != 5'd0);
         if (s[8:5] == 4'd3) host_rst_n = ~host_rst_n;
         nvm_done     = (s[10:9] == 2'd0);
         nvm_wake_bit = s[11];
         mem_en_wr    = (s[14:12] == 3'd1);
         pwr_good     = !(j == 1500);
         tick();
      end
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule